// File: doc/BRIEF.md
# Double-Buffered Clocked Serial Transmitter

This block is the transmit side of a clocked serial I/O port. A byte written by the CPU passes through an optional four-entry queue, then an optional holding register, and finally reaches a shift register. The shift register sends the byte on a single data line, least significant bit first, timed by a serial clock. The block either generates that clock itself by dividing the system clock, or follows a serial clock driven from outside.

Three mode inputs choose the layout. They are the double-buffer enable, the queue enable (which only has an effect with double buffering on) and the clock-output select. When the block owns the clock, the clock stops whenever nothing is left to send, so the line can never run dry. When an outside device owns the clock, the block reports a sticky under-run if a new frame starts while it has nothing loaded. A status-read strobe clears that flag. A transmit interrupt pulse tells the CPU when to supply the next byte: in double-buffer layouts it fires when the holding stage is handed to the shifter, and otherwise it fires when the frame has finished.

Top module: `sertx_dbuf`

## Requirements
- R1: After reset the outputs are: `bufEmpty`=1, `txIrq`=0, `fifoFull`=0, `underrunErr`=0, `sclkOut`=1 and `txData`=1.
- R2: A frame carries 8 bits, least significant bit first. `txData` changes only on falling serial-clock edges, so a receiver samples each bit on the rising edge that follows.
- R3: With `dblBufEn`=0, a write loads the shift register only while `bufEmpty`=1 (shift register free). A write made during a frame is dropped. `txIrq` pulses for one cycle when the frame's last rising edge ends it, and never at load time.
- R4: With `dblBufEn`=1 and `fifoEn`=0, a write fills the holding register if it is empty. When the shift register is free, the holding register moves into it, and in that cycle `txIrq` pulses for one cycle and `bufEmpty` reads 1.
- R5: With double buffering on, `bufEmpty` reads 0 from the clock edge that writes a byte into the empty holding register.
- R6: With `dblBufEn`=1 and `fifoEn`=1, writes enter the queue. The queue head moves into the holding register whenever that register is empty or being emptied in the same cycle. A hand-over to the shifter therefore refills the holding register at once, and `bufEmpty` stays 0 if the queue had data.
- R7: The queue holds 4 bytes. `fifoFull`=1 while all 4 are occupied, and a write made while it is full is dropped.
- R8: In clock-output mode (`clkOutMode`=1), `sclkOut` has half-periods of `CLK_DIV` system cycles. It runs only while a byte sits in the shift register, and it parks high after the last frame.
- R9: In clock-output mode `underrunErr` never rises.
- R10: In clock-input mode (`clkOutMode`=0), `sclkIn` is synchronised through two flops, and its falling and rising edges time the frame exactly as in R2.
- R11: In clock-input mode with `dblBufEn`=1 and `fifoEn`=0, the first falling `sclkIn` edge after a completed frame sets `underrunErr` if the shift register is still empty at that point. The flag stays set.
- R12: A one-cycle `statusRd` pulse clears `underrunErr`. A new under-run in the same cycle takes priority over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| dblBufEn | input | 1 | 1 places the holding register in front of the shifter |
| fifoEn | input | 1 | 1 places the 4-entry queue in front of the holding register (only with dblBufEn=1) |
| clkOutMode | input | 1 | 1 = block drives the serial clock, 0 = follows sclkIn |
| wrEn | input | 1 | CPU write strobe |
| wrData | input | 8 | CPU write data |
| statusRd | input | 1 | Status read strobe, clears the under-run flag |
| sclkIn | input | 1 | External serial clock, asynchronous |
| sclkOut | output | 1 | Generated serial clock, idles high |
| txData | output | 1 | Serial data line |
| txIrq | output | 1 | One-cycle transmit interrupt pulse |
| bufEmpty | output | 1 | The stage that takes the next write is free |
| fifoFull | output | 1 | Queue holds 4 bytes |
| underrunErr | output | 1 | Sticky under-run flag |

## Verification
A hand-over that goes wrong between stages shows up at the data line. A byte may be lost, repeated or reordered, and that becomes visible when the frame carrying it is shifted out, roughly 8·2·`CLK_DIV` cycles after the fault. Interrupt and empty-flag faults show up within one or two cycles of the write or hand-over that should have produced them. A clock-gating fault shows up as extra serial-clock edges during idle time, or as low phases of the wrong length. Under-run faults appear on the first external falling edge after a frame ends.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  // Strobes from control to datapath, all valid for one system cycle.
  typedef struct packed {
    logic loadShiftCpu;  // CPU byte straight into the shifter
    logic loadHoldCpu;   // CPU byte into the holding register
    logic pushFifo;      // CPU byte into the queue
    logic popFifo;       // queue head into the holding register
    logic xferHold;      // holding register into the shifter
    logic startFrame;    // first falling edge of a frame
    logic shiftBit;      // later falling edges of a frame
    logic endFrame;      // last rising edge of a frame
  } strobe_t;

endpackage

// File: rtl/sertx_dp.sv
module sertx_dp #(
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  sertx_pkg::strobe_t  stb,
  input  logic [DATA_W-1:0]   wrData,
  output logic                shBusy,
  output logic                holdValid,
  output logic                fifoEmpty,
  output logic                fifoFull,
  output logic                txData
);
  localparam int PTR_W = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(FIFO_DEPTH - 1);

  logic [DATA_W-1:0] fifoMem [FIFO_DEPTH];
  logic [PTR_W-1:0]  rdPtr, wrPtr;
  logic [CNT_W-1:0]  fifoCnt;
  logic [DATA_W-1:0] holdReg, shReg;
  logic              outBit;

  assign fifoEmpty = (fifoCnt == '0);
  assign fifoFull  = (fifoCnt == CNT_W'(FIFO_DEPTH));
  assign outBit    = stb.startFrame | stb.shiftBit;

  always_ff @(posedge clk) begin
    if (stb.pushFifo) fifoMem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr   <= '0;
      wrPtr   <= '0;
      fifoCnt <= '0;
    end else begin
      if (stb.pushFifo) wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + PTR_W'(1);
      if (stb.popFifo)  rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + PTR_W'(1);
      case ({stb.pushFifo, stb.popFifo})
        2'b10:   fifoCnt <= fifoCnt + CNT_W'(1);
        2'b01:   fifoCnt <= fifoCnt - CNT_W'(1);
        default: fifoCnt <= fifoCnt;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg   <= '0;
      holdValid <= 1'b0;
    end else if (stb.popFifo) begin
      holdReg   <= fifoMem[rdPtr];
      holdValid <= 1'b1;
    end else if (stb.loadHoldCpu) begin
      holdReg   <= wrData;
      holdValid <= 1'b1;
    end else if (stb.xferHold) begin
      holdValid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg  <= '0;
      shBusy <= 1'b0;
      txData <= 1'b1;
    end else begin
      if (stb.xferHold) begin
        shReg  <= holdReg;
        shBusy <= 1'b1;
      end else if (stb.loadShiftCpu) begin
        shReg  <= wrData;
        shBusy <= 1'b1;
      end else begin
        if (outBit) begin
          txData <= shReg[0];
          shReg  <= {1'b0, shReg[DATA_W-1:1]};
        end
        if (stb.endFrame) shBusy <= 1'b0;
      end
    end
  end

  // R7: control must never push into a full queue
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rstN)
    stb.pushFifo |-> (fifoCnt < CNT_W'(FIFO_DEPTH)));

  // R6: the holding register is loaded from one source at a time
  p_hold_one_source_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.popFifo, stb.loadHoldCpu}));

  // R4: the shifter is only reloaded while free
  p_shift_free_r4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.xferHold || stb.loadShiftCpu) |-> !shBusy);

endmodule

// File: rtl/sertx_ctrl.sv
module sertx_ctrl #(
  parameter int DATA_W  = 8,
  parameter int CLK_DIV = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               dblBufEn,
  input  logic               fifoEn,
  input  logic               clkOutMode,
  input  logic               wrEn,
  input  logic               statusRd,
  input  logic               sclkIn,
  input  logic               shBusy,
  input  logic               holdValid,
  input  logic               fifoEmpty,
  input  logic               fifoFull,
  output sertx_pkg::strobe_t stb,
  output logic               sclkOut,
  output logic               txIrq,
  output logic               underrunErr
);
  localparam int BIT_W = $clog2(DATA_W);
  localparam int DIV_W = $clog2(CLK_DIV + 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);
  localparam logic [DIV_W-1:0] DIV_TOP  = DIV_W'(CLK_DIV - 1);

  logic [2:0]       syncQ;
  logic [DIV_W-1:0] divCnt;
  logic [BIT_W-1:0] bitCnt;
  logic sclkReg, started, afterFrame;
  logic runClk, divWrap, fallEv, riseEv, fifoOn, underHit;

  always_comb begin
    fifoOn  = dblBufEn && fifoEn;
    runClk  = clkOutMode && (shBusy || !sclkReg);
    divWrap = runClk && (divCnt == DIV_TOP);
    if (clkOutMode) begin
      fallEv = divWrap && sclkReg;
      riseEv = divWrap && !sclkReg;
    end else begin
      fallEv = syncQ[2] && !syncQ[1];
      riseEv = !syncQ[2] && syncQ[1];
    end
    stb.loadShiftCpu = wrEn && !dblBufEn && !shBusy;
    stb.loadHoldCpu  = wrEn && dblBufEn && !fifoEn && !holdValid;
    stb.pushFifo     = wrEn && fifoOn && !fifoFull;
    stb.xferHold     = dblBufEn && holdValid && !shBusy;
    stb.popFifo      = fifoOn && !fifoEmpty && (!holdValid || stb.xferHold);
    stb.startFrame   = fallEv && shBusy && !started;
    stb.shiftBit     = fallEv && started;
    stb.endFrame     = riseEv && started && (bitCnt == LAST_BIT);
    underHit = fallEv && afterFrame && !shBusy && !clkOutMode && dblBufEn && !fifoEn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ       <= 3'b111;
      divCnt      <= '0;
      sclkReg     <= 1'b1;
      started     <= 1'b0;
      bitCnt      <= '0;
      afterFrame  <= 1'b0;
      underrunErr <= 1'b0;
      txIrq       <= 1'b0;
    end else begin
      syncQ  <= {syncQ[1:0], sclkIn};
      divCnt <= (!runClk || divWrap) ? '0 : divCnt + DIV_W'(1);
      if (!clkOutMode)  sclkReg <= 1'b1;
      else if (divWrap) sclkReg <= !sclkReg;
      if (stb.startFrame) begin
        started <= 1'b1;
        bitCnt  <= '0;
      end else if (stb.shiftBit) begin
        bitCnt  <= bitCnt + BIT_W'(1);
      end else if (stb.endFrame) begin
        started <= 1'b0;
      end
      if (stb.endFrame && !clkOutMode) afterFrame <= 1'b1;
      else if (fallEv)                 afterFrame <= 1'b0;
      if (underHit)      underrunErr <= 1'b1;
      else if (statusRd) underrunErr <= 1'b0;
      txIrq <= dblBufEn ? stb.xferHold : stb.endFrame;
    end
  end

  assign sclkOut = sclkReg;

  // R9: no under-run while the block owns the clock
  p_no_underrun_clkout_r9: assert property (@(posedge clk) disable iff (!rstN)
    (clkOutMode && $past(clkOutMode)) |-> !$rose(underrunErr));

  // R8: an idle generated clock stays parked high
  p_idle_high_r8: assert property (@(posedge clk) disable iff (!rstN)
    (clkOutMode && !shBusy && sclkOut) |=> sclkOut);

  // R4: interrupt coincides with an empty holding stage
  p_irq_empty_r4: assert property (@(posedge clk) disable iff (!rstN)
    (txIrq && dblBufEn && !fifoEn) |-> !holdValid);

  // R12: the flag only drops after a status read
  p_clear_on_read_r12: assert property (@(posedge clk) disable iff (!rstN)
    $fell(underrunErr) |-> $past(statusRd));

endmodule

// File: rtl/sertx_dbuf.sv
module sertx_dbuf #(
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 4,
  parameter int CLK_DIV    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dblBufEn,
  input  logic              fifoEn,
  input  logic              clkOutMode,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              statusRd,
  input  logic              sclkIn,
  output logic              sclkOut,
  output logic              txData,
  output logic              txIrq,
  output logic              bufEmpty,
  output logic              fifoFull,
  output logic              underrunErr
);
  sertx_pkg::strobe_t stb;
  logic shBusy, holdValid, fifoEmpty;

  sertx_ctrl #(.DATA_W(DATA_W), .CLK_DIV(CLK_DIV)) u_ctrl (
    .clk(clk), .rstN(rstN), .dblBufEn(dblBufEn), .fifoEn(fifoEn),
    .clkOutMode(clkOutMode), .wrEn(wrEn), .statusRd(statusRd), .sclkIn(sclkIn),
    .shBusy(shBusy), .holdValid(holdValid), .fifoEmpty(fifoEmpty),
    .fifoFull(fifoFull), .stb(stb), .sclkOut(sclkOut), .txIrq(txIrq),
    .underrunErr(underrunErr)
  );

  sertx_dp #(.DATA_W(DATA_W), .FIFO_DEPTH(FIFO_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData), .shBusy(shBusy),
    .holdValid(holdValid), .fifoEmpty(fifoEmpty), .fifoFull(fifoFull),
    .txData(txData)
  );

  assign bufEmpty = dblBufEn ? !holdValid : !shBusy;

endmodule

// File: tb/sertx_dbuf_bench.sv
module sertx_dbuf_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;

  logic clk = 1'b0, rstN = 1'b0;
  logic dblBufEn = 1'b1, fifoEn = 1'b0, clkOutMode = 1'b1;
  logic wrEn = 1'b0, statusRd = 1'b0, sclkIn = 1'b1;
  logic [7:0] wrData = '0;
  logic sclkOut, txData, txIrq, bufEmpty, fifoFull, underrunErr, sclkLine;

  int checks = 0, errors = 0;
  int irqCnt = 0, irqFullCnt = 0, riseCnt = 0, lowCnt = 0, rxN = 0, rxBits = 0;
  bit rxOn = 1'b1;
  logic [7:0] rxShift = '0;
  logic [7:0] rxBytes [0:63];
  logic [7:0] expBytes [0:63];

  sertx_dbuf #(.DATA_W(8), .FIFO_DEPTH(4), .CLK_DIV(DIV)) u_sertx_dbuf (
    .clk(clk), .rstN(rstN), .dblBufEn(dblBufEn), .fifoEn(fifoEn),
    .clkOutMode(clkOutMode), .wrEn(wrEn), .wrData(wrData), .statusRd(statusRd),
    .sclkIn(sclkIn), .sclkOut(sclkOut), .txData(txData), .txIrq(txIrq),
    .bufEmpty(bufEmpty), .fifoFull(fifoFull), .underrunErr(underrunErr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sclkLine = clkOutMode ? sclkOut : sclkIn;

  always @(negedge clk) begin
    if (rstN && txIrq) begin
      irqCnt++;
      if (!bufEmpty) irqFullCnt++;
    end
    if (rstN && clkOutMode && !sclkOut) lowCnt++;
  end

  always @(posedge sclkLine) begin
    if (rstN) begin
      riseCnt++;
      if (rxOn) begin
        rxShift = {txData, rxShift[7:1]};
        rxBits++;
        if (rxBits == 8) begin
          rxBytes[rxN] = rxShift;
          rxN++;
          rxBits = 0;
        end
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doReset(bit dbl, bit fif, bit cko);
    @(negedge clk);
    rstN = 1'b0; dblBufEn = dbl; fifoEn = fif; clkOutMode = cko;
    wrEn = 1'b0; statusRd = 1'b0; sclkIn = 1'b1;
    repeat (3) @(negedge clk);
    irqCnt = 0; irqFullCnt = 0; riseCnt = 0; lowCnt = 0; rxN = 0; rxBits = 0;
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic writeByte(logic [7:0] b);
    wrEn = 1'b1; wrData = b;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitRx(int n);
    for (int i = 0; i < 4000 && rxN < n; i++) @(negedge clk);
    idle(12);
  endtask

  task automatic extPulse();
    sclkIn = 1'b0; idle(8);
    sclkIn = 1'b1; idle(8);
  endtask

  // Acceptance rule per mode (R3, R4, R7): 0 = direct, 1 = holding, 2 = queue
  function automatic bit canAccept(int mode, logic empty, logic full);
    return (mode == 2) ? !full : empty;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));

    // R1 reset state
    doReset(1, 0, 1);
    chk("R1 bufEmpty", bufEmpty, 1);
    chk("R1 txIrq", txIrq, 0);
    chk("R1 fifoFull", fifoFull, 0);
    chk("R1 underrunErr", underrunErr, 0);
    chk("R1 sclkOut", sclkOut, 1);
    chk("R1 txData", txData, 1);

    // R4 / R5 holding register, clock-output mode
    writeByte(8'hA5);
    chk("R5 bufEmpty after write", bufEmpty, 0);
    @(negedge clk);
    chk("R4 irq at handover", txIrq, 1);
    chk("R4 bufEmpty at handover", bufEmpty, 1);
    writeByte(8'h3C);
    chk("R5 bufEmpty with shifter busy", bufEmpty, 0);
    idle(3);
    chk("R5 bufEmpty held", bufEmpty, 0);
    waitRx(2);
    chk("R2 frame count", rxN, 2);
    chk("R2 byte0", rxBytes[0], 8'hA5);
    chk("R2 byte1", rxBytes[1], 8'h3C);
    chk("R8 rises for two frames", riseCnt, 16);
    idle(60);
    chk("R8 no idle rises", riseCnt, 16);
    chk("R8 parked high", sclkOut, 1);
    chk("R9 no underrun in clock-output", underrunErr, 0);
    chk("R4 irq count", irqCnt, 2);

    // R3 direct load
    doReset(0, 0, 1);
    writeByte(8'h96);
    idle(3);
    chk("R3 no irq at load", irqCnt, 0);
    chk("R3 bufEmpty busy", bufEmpty, 0);
    writeByte(8'h11);
    waitRx(1);
    idle(80);
    chk("R3 irq after frame", irqCnt, 1);
    chk("R3 busy write dropped", rxN, 1);
    chk("R3 byte", rxBytes[0], 8'h96);
    chk("R8 low cycles per frame", lowCnt, 8 * DIV);

    // R6 queue timing
    doReset(1, 1, 1);
    writeByte(8'h5A);
    @(negedge clk);
    chk("R6 head in holding", bufEmpty, 0);
    chk("R6 no irq yet", txIrq, 0);
    @(negedge clk);
    chk("R6 irq at handover", txIrq, 1);
    waitRx(1);
    chk("R6 byte", rxBytes[0], 8'h5A);

    // R7 queue full, R6 same-cycle refill
    doReset(1, 1, 1);
    for (int i = 0; i < 8; i++) begin
      expBytes[i] = 8'(8'h20 + i * 7);
      writeByte(expBytes[i]);
      @(negedge clk);
    end
    chk("R7 full flag", fifoFull, 1);
    waitRx(6);
    idle(150);
    chk("R7 accepted count", rxN, 6);
    for (int i = 0; i < 6; i++) chk("R7 order", rxBytes[i], expBytes[i]);
    chk("R7 full cleared", fifoFull, 0);
    chk("R6 refilled handovers", irqFullCnt, 4);

    // R10 / R11 / R12 clock-input mode
    doReset(1, 0, 0);
    writeByte(8'hC3);
    idle(2);
    writeByte(8'h7E);
    idle(2);
    rxOn = 1'b1;
    for (int i = 0; i < 16; i++) extPulse();
    rxOn = 1'b0;
    idle(4);
    chk("R10 frames", rxN, 2);
    chk("R10 byte0", rxBytes[0], 8'hC3);
    chk("R10 byte1", rxBytes[1], 8'h7E);
    chk("R11 no underrun while fed", underrunErr, 0);
    chk("R8 clock unused in input mode", sclkOut, 1);
    extPulse();
    chk("R11 underrun set", underrunErr, 1);
    idle(30);
    chk("R11 sticky", underrunErr, 1);
    statusRd = 1'b1; @(negedge clk); statusRd = 1'b0;
    chk("R12 cleared by read", underrunErr, 0);
    rxOn = 1'b1;

    // Random rounds in clock-output mode (R2, R3, R4, R7)
    for (int r = 0; r < 8; r++) begin
      int mode = int'($urandom % 3);
      int n = 1 + int'($urandom % 5);
      doReset(mode != 0, mode == 2, 1);
      for (int i = 0; i < n; i++) begin
        expBytes[i] = 8'($urandom);
        for (int w = 0; w < 2000 && !canAccept(mode, bufEmpty, fifoFull); w++) @(negedge clk);
        writeByte(expBytes[i]);
        idle(int'($urandom % 20));
      end
      waitRx(n);
      idle(20);
      chk("R2 random count", rxN, n);
      for (int i = 0; i < n; i++) chk("R2 random byte", rxBytes[i], expBytes[i]);
      chk("R3 R4 random irq count", irqCnt, n);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule